// File: doc/BRIEF.md
# Tagged Byte-Masked Memory Controller

A single-port synchronous word memory driven by a valid/ready command stream and answering on a valid/ready response stream. Every command carries a word address, a write flag, a 16-bit data word, a 2-bit byte-lane mask and an 8-bit context tag. A write changes only the byte lanes its mask enables and produces no response beat. A read produces exactly one response beat: the stored word plus the unchanged context tag of the read command.

The context tag is opaque to the block. A requester uses it to match each response to the read that caused it. There is no burst field. A run over consecutive addresses is simply a sequence of back-to-back commands, one accepted per cycle. Storage reads as zero from reset, so software never sees stale contents.

Top module: `mem_tag_ctrl`

## Requirements
- R1: The word address is ADDR_W bits wide (default 11). The memory holds 2^ADDR_W words of 16 bits, and every address from 0 to 2^ADDR_W-1 stores its own word.
- R2: Mask bit 0 enables the write of data bits 7:0 and mask bit 1 enables data bits 15:8. A byte lane whose mask bit is 0 keeps its old value, and a mask of 00 changes nothing.
- R3: An accepted write never produces a response beat: rsp_valid_o stays low in the cycle after it.
- R4: A read response carries, on rsp_ctx_o, the cmd_ctx_i value of its read command unchanged.
- R5: After reset, every byte that has not been written since that reset reads as 0x00, including bytes written before the reset.
- R6: A read accepted in any cycle after a write to the same address, including the very next cycle, returns the bytes that write updated.
- R7: A read accepted at a clock edge raises rsp_valid_o right after that edge, with rsp_data_o and rsp_ctx_o valid.
- R8: While rsp_valid_o is high and rsp_ready_i is low, cmd_ready_o is low and no command (read or write) is accepted. rsp_valid_o, rsp_data_o and rsp_ctx_o then hold steady.
- R9: Responses leave in the order in which their reads were accepted, one per cycle when rsp_ready_i stays high.
- R10: During and right after reset, rsp_valid_o is low and cmd_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be accepted this cycle |
| cmd_addr_i | input | ADDR_W | Word address |
| cmd_we_i | input | 1 | 1 = write, 0 = read |
| cmd_mask_i | input | 2 | Byte-lane write enables, bit 0 = bits 7:0 |
| cmd_data_i | input | 16 | Write data |
| cmd_ctx_i | input | 8 | Context tag returned with a read |
| rsp_valid_o | output | 1 | Response beat present |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_data_o | output | 16 | Read data |
| rsp_ctx_o | output | 8 | Context tag of the read |

## Verification
The bench targets partial masks, which catch swapped lanes or a whole-word write: a masked-off byte would be lost or land in the wrong half. It issues a read in the cycle right after a write to the same address, where a design that forwards late returns the old bytes. It holds the response consumer off while a write waits. A design that ignored back-pressure would drop the response, change the held data, or sneak the write in; a later read then exposes the write. It also resets after writes to show that stale contents read as zero, and it sends a write between reads to catch a design that emits a response beat for a write.

// File: rtl/mem_tag_pkg.sv
package mem_tag_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned CTX_W  = 8;
endpackage

// File: rtl/mem_lane.sv
module mem_lane #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [BYTE_W-1:0] rd_q;
  logic              hit_q;

  // storage carries no reset; vld_q masks never-written bytes
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rd_q <= mem_q[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (we_i) vld_q[addr_i] <= 1'b1;
      if (re_i) hit_q <= vld_q[addr_i];
    end
  end

  assign rdata_o = hit_q ? rd_q : '0;

  AST_FRESH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !we_i && !vld_q[addr_i] |=> rdata_o == '0); // R5
  AST_LANE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(addr_i)]); // R6
endmodule

// File: rtl/rsp_stage.sv
module rsp_stage #(
  parameter int unsigned CTX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [CTX_W-1:0] ctx_o,
  output logic             stall_o
);
  logic             valid_q;
  logic [CTX_W-1:0] ctx_q;

  assign stall_o = valid_q && !ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ctx_q   <= '0;
    end else begin
      valid_q <= load_i || stall_o;
      if (load_i) ctx_q <= ctx_i;
    end
  end

  assign valid_o = valid_q;
  assign ctx_o   = ctx_q;

  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i |=> valid_q && $stable(ctx_q)); // R8
  AST_NO_LOAD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !load_i); // R8
endmodule

// File: rtl/mem_tag_ctrl.sv
module mem_tag_ctrl
  import mem_tag_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_we_i,
  input  logic [LANES-1:0]  cmd_mask_i,
  input  logic [WORD_W-1:0] cmd_data_i,
  input  logic [CTX_W-1:0]  cmd_ctx_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic [CTX_W-1:0]  rsp_ctx_o
);
  logic fire, rd_fire, wr_fire, stall;

  assign cmd_ready_o = !stall;
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign rd_fire     = fire && !cmd_we_i;
  assign wr_fire     = fire && cmd_we_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mem_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .re_i    (rd_fire),
      .we_i    (wr_fire && cmd_mask_i[g]),
      .addr_i  (cmd_addr_i),
      .wdata_i (cmd_data_i[g*BYTE_W +: BYTE_W]),
      .rdata_o (rsp_data_o[g*BYTE_W +: BYTE_W])
    );
  end

  rsp_stage #(.CTX_W(CTX_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rd_fire),
    .ctx_i   (cmd_ctx_i),
    .ready_i (rsp_ready_i),
    .valid_o (rsp_valid_o),
    .ctx_o   (rsp_ctx_o),
    .stall_o (stall)
  );

  AST_WR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_we_i |=> !rsp_valid_o); // R3
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && !cmd_we_i |=> rsp_valid_o); // R7
  AST_CTX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && !cmd_we_i |=> rsp_ctx_o == $past(cmd_ctx_i)); // R4
  AST_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !cmd_ready_o); // R8
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> $stable(rsp_data_o)); // R8
endmodule

// File: tb/tb_mem_tag_ctrl.sv
module tb_mem_tag_ctrl;
  localparam int unsigned AW = 11;
  localparam int unsigned TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready, cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [1:0]    cmd_mask = '0;
  logic [15:0]   cmd_data = '0, rsp_data;
  logic [7:0]    cmd_ctx = '0, rsp_ctx;
  logic          rsp_valid, rsp_ready = 1'b1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mem_tag_ctrl #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_addr_i(cmd_addr),
    .cmd_we_i(cmd_we), .cmd_mask_i(cmd_mask), .cmd_data_i(cmd_data), .cmd_ctx_i(cmd_ctx),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data), .rsp_ctx_o(rsp_ctx)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // called at negedge: drive, cross one posedge, return at next negedge
  task automatic cyc(bit v, bit we, logic [AW-1:0] a, logic [15:0] d, logic [1:0] m, logic [7:0] c);
    cmd_valid = v; cmd_we = we; cmd_addr = a; cmd_data = d; cmd_mask = m; cmd_ctx = c;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [7:0] c, logic [15:0] exp);
    cyc(1, 0, a, 16'h0, 2'b00, c);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " data"}, 32'(rsp_data), 32'(exp));
    chk({req, " ctx"}, 32'(rsp_ctx), 32'(c));
  endtask

  task automatic t_reset;
    chk("R10 ready in reset", 32'(cmd_ready), 32'd1);
    chk("R10 valid in reset", 32'(rsp_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R10 ready after reset", 32'(cmd_ready), 32'd1);
    chk("R10 valid after reset", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_fresh;
    rd_chk("R5 R7 unwritten", 11'd5, 8'h3C, 16'h0000);
  endtask

  task automatic t_mask;
    cyc(1, 1, 11'd10, 16'hA1B2, 2'b11, 8'h00);
    chk("R3 no rsp on write", 32'(rsp_valid), 32'd0);
    rd_chk("R2 full write", 11'd10, 8'h11, 16'hA1B2);
    cyc(1, 1, 11'd10, 16'h55FF, 2'b01, 8'h00);
    rd_chk("R2 low lane only", 11'd10, 8'h12, 16'hA1FF);
    cyc(1, 1, 11'd10, 16'h3366, 2'b10, 8'h00);
    rd_chk("R2 high lane only", 11'd10, 8'h13, 16'h33FF);
    cyc(1, 1, 11'd10, 16'h0000, 2'b00, 8'h00);
    rd_chk("R2 empty mask", 11'd10, 8'h14, 16'h33FF);
    cyc(1, 1, 11'd12, 16'hBEEF, 2'b10, 8'h00);
    rd_chk("R2 R5 half-written word", 11'd12, 8'h15, 16'hBE00);
  endtask

  task automatic t_raw;
    cyc(1, 1, 11'(TOP), 16'hC0DE, 2'b11, 8'h00);
    rd_chk("R6 R1 top address next cycle", 11'(TOP), 8'hE1, 16'hC0DE);
    cyc(1, 1, 11'd0, 16'h1234, 2'b11, 8'h00);
    rd_chk("R6 R1 address zero", 11'd0, 8'hE2, 16'h1234);
    rd_chk("R1 neighbour untouched", 11'd1, 8'hE3, 16'h0000);
  endtask

  task automatic t_write_between;
    cyc(1, 0, 11'd0, 16'h0, 2'b00, 8'h21);
    chk("R7 read beat", 32'(rsp_valid), 32'd1);
    cyc(1, 1, 11'd20, 16'h7777, 2'b11, 8'h22);
    chk("R3 write after read silent", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_stall;
    rsp_ready = 1'b0;
    cyc(1, 0, 11'd10, 16'h0, 2'b00, 8'h5A);
    chk("R8 beat present", 32'(rsp_valid), 32'd1);
    chk("R8 cmd blocked", 32'(cmd_ready), 32'd0);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, 11'd10, 16'h0000, 2'b11, 8'h99);
      chk("R8 held valid", 32'(rsp_valid), 32'd1);
      chk("R8 held data", 32'(rsp_data), 32'h33FF);
      chk("R8 held ctx", 32'(rsp_ctx), 32'h5A);
    end
    rsp_ready = 1'b1;
    cyc(0, 0, 11'd0, 16'h0, 2'b00, 8'h00);
    chk("R8 beat popped", 32'(rsp_valid), 32'd0);
    rd_chk("R8 blocked write ignored", 11'd10, 8'h5B, 16'h33FF);
  endtask

  task automatic t_order;
    for (int i = 0; i < 4; i++) cyc(1, 1, 11'(100 + i), 16'(16'h1000 * i + i), 2'b11, 8'h00);
    for (int i = 0; i < 4; i++)
      rd_chk("R9 ordered burst", 11'(100 + i), 8'(8'h80 + i), 16'(16'h1000 * i + i));
    cyc(0, 0, 11'd0, 16'h0, 2'b00, 8'h00);
    chk("R9 no extra beat", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_rereset;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R10 valid after re-reset", 32'(rsp_valid), 32'd0);
    rd_chk("R5 stale word cleared", 11'd10, 8'h71, 16'h0000);
    rd_chk("R5 stale top cleared", 11'(TOP), 8'h72, 16'h0000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fresh();
    t_mask();
    t_raw();
    t_write_between();
    t_stall();
    t_order();
    t_rereset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule